// File: doc/BRIEF.md
# Open-Drain Output Port with Shared Beep Tone

This block drives a small open-drain output port. Each pin is modelled as a drive-low enable. A 1 pulls the pin low. A 0 releases it, and an external pull-up or high impedance then sets the level. Software-style commands arrive as single-cycle strobes. A port write loads the output latch. A beep command switches bit 0 between following that latch and carrying a square-wave tone, and it picks one of two tone rates.

The tone is made by dividing the block clock with a half-period counter. With a 75 kHz clock, the default half periods give about 1.5 kHz and 3 kHz at 50% duty. The output latch is kept apart from the tone path. Writes made while the tone runs are remembered and appear as soon as bit 0 goes back to latch mode. A backup request releases every pin. The pins stay released until the next port write or beep command.

Top module: `beep_port`

## Requirements
- R1: After reset, every pull-low enable is 0. The latch holds all ones and bit 0 is in latch mode.
- R2: Once a port write has been clocked in, while bit 0 is in latch mode and no backup is pending, pull-low bit i equals the inverse of the written data bit i. A latch value of 0 means the pin is driven low.
- R3: When a beep command with control bit 2 set to 1 is clocked in with tone code 00, bit 0 is released for HALF_A cycles and then pulled low for HALF_A cycles, and this repeats. The count starts at the clock edge that takes the command.
- R4: Tone code 01 (control bits 1:0) gives the same pattern with a half period of HALF_B cycles.
- R5: Tone codes 10 and 11 behave exactly like code 00.
- R6: While bit 0 carries the tone, a port write does not disturb the bit 0 pin pattern.
- R7: Bit 1 always follows its latch, even while bit 0 carries the tone. A bit-1 pin changes only after a port write, beep command or backup request.
- R8: A beep command with control bit 2 set to 0 returns bit 0 to latch mode. From the next cycle the pin shows the current latch value, including a value written during the tone.
- R9: From the cycle after a backup request, all pull-low enables are 0. They stay 0, while the request is held and after it drops, until a port write or beep command is clocked in with no backup request present.
- R10: A port write or beep command that ends a released state puts the pins back under latch and mode control. A port write made during that state also loads the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (tone reference) |
| rst_n | input | 1 | Active-low synchronous reset |
| backup_i | input | 1 | Backup request: release all pins |
| port_wr_i | input | 1 | Port write strobe |
| port_data_i | input | PORT_W | Port write data (0 = drive low) |
| beep_wr_i | input | 1 | Beep command strobe |
| beep_ctrl_i | input | 3 | Bit 2: tone on bit 0; bits 1:0: tone code |
| pin_pull_low_o | output | PORT_W | Per-pin pull-low enable |

## Verification
The bench builds the block with HALF_A = 5 and HALF_B = 2. Several full tone periods of both rates therefore fit in a few dozen cycles, and each half period can be checked cycle by cycle. The short half periods also let a port write land in the middle of a tone phase. This shows that the bit 0 pattern is undisturbed while bit 1 takes the new value. A latch-mode vector table is walked first. Directed sequences then cover every tone code, the return to latch mode, and backup release with both kinds of wake-up.

// File: rtl/beep_port_pkg.sv
package beep_port_pkg;
    localparam int CTRL_W    = 3;
    localparam int MODE_BIT  = 2;
    localparam logic [1:0] CODE_ALT = 2'b01;

    typedef struct packed {
        logic tone_mode;
        logic sel_alt;
        logic hiz;
    } port_ctl_t;
endpackage

// File: rtl/beep_tone_div.sv
module beep_tone_div #(
    parameter int HALF_A = 25,
    parameter int HALF_B = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    input  logic sel_alt_i,
    output logic tone_rel_o
);
    localparam int HMAX = (HALF_A > HALF_B) ? HALF_A : HALF_B;
    localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t s_d, s_q;
    logic [CW-1:0] last_w;

    always_comb begin
        last_w = sel_alt_i ? CW'(HALF_B - 1) : CW'(HALF_A - 1);
        s_d    = s_q;
        if (restart_i || !run_i) begin
            s_d.cnt = '0;
            s_d.lvl = 1'b1;
        end else if (s_q.cnt == last_w) begin
            s_d.cnt = '0;
            s_d.lvl = ~s_q.lvl;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.lvl <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tone_rel_o = s_q.lvl;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt < CW'(HMAX)));

    // R4
    toggle_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.lvl) && $past(run_i) && !$past(restart_i))
        |-> ($past(s_q.cnt) == $past(last_w)));
endmodule

// File: rtl/beep_pin_mux.sv
module beep_pin_mux #(
    parameter int PORT_W = 2
) (
    input  logic [PORT_W-1:0] latch_i,
    input  logic              tone_mode_i,
    input  logic              tone_rel_i,
    input  logic              hiz_i,
    output logic [PORT_W-1:0] pull_low_o
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i == 0) begin : g_shared
            always_comb begin
                if (hiz_i)            pull_low_o[i] = 1'b0;
                else if (tone_mode_i) pull_low_o[i] = ~tone_rel_i;
                else                  pull_low_o[i] = ~latch_i[i];
            end
        end else begin : g_plain
            always_comb begin
                pull_low_o[i] = hiz_i ? 1'b0 : ~latch_i[i];
            end
        end
    end
endmodule

// File: rtl/beep_port.sv
module beep_port
    import beep_port_pkg::*;
#(
    parameter int PORT_W = 2,
    parameter int HALF_A = 25,
    parameter int HALF_B = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              backup_i,
    input  logic              port_wr_i,
    input  logic [PORT_W-1:0] port_data_i,
    input  logic              beep_wr_i,
    input  logic [CTRL_W-1:0] beep_ctrl_i,
    output logic [PORT_W-1:0] pin_pull_low_o
);
    port_ctl_t         ctl_d, ctl_q;
    logic [PORT_W-1:0] latch_d, latch_q;
    logic              tone_rel;

    always_comb begin
        ctl_d   = ctl_q;
        latch_d = latch_q;
        if (port_wr_i) latch_d = port_data_i;
        if (beep_wr_i) begin
            ctl_d.tone_mode = beep_ctrl_i[MODE_BIT];
            ctl_d.sel_alt   = (beep_ctrl_i[1:0] == CODE_ALT);
        end
        if (backup_i)                     ctl_d.hiz = 1'b1;
        else if (port_wr_i || beep_wr_i)  ctl_d.hiz = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            latch_q <= '1;
        end else begin
            ctl_q   <= ctl_d;
            latch_q <= latch_d;
        end
    end

    beep_tone_div #(
        .HALF_A (HALF_A),
        .HALF_B (HALF_B)
    ) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (beep_wr_i),
        .run_i      (ctl_q.tone_mode),
        .sel_alt_i  (ctl_q.sel_alt),
        .tone_rel_o (tone_rel)
    );

    beep_pin_mux #(
        .PORT_W (PORT_W)
    ) i_mux (
        .latch_i     (latch_q),
        .tone_mode_i (ctl_q.tone_mode),
        .tone_rel_i  (tone_rel),
        .hiz_i       (ctl_q.hiz),
        .pull_low_o  (pin_pull_low_o)
    );

    // R9
    backup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |=> (pin_pull_low_o == '0));

    // R2
    gp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_i && !beep_wr_i && !backup_i && !ctl_q.tone_mode)
        |=> (pin_pull_low_o == ~$past(port_data_i)));

    if (PORT_W > 1) begin : g_hi_chk
        // R7
        hi_bits_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pin_pull_low_o[PORT_W-1:1])
            |-> $past(port_wr_i || beep_wr_i || backup_i));
    end
endmodule

// File: tb/test_beep_port.sv
module test_beep_port;
    localparam int PW = 2;
    localparam int HA = 5;
    localparam int HB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          backup_i = 1'b0;
    logic          port_wr_i = 1'b0;
    logic [PW-1:0] port_data_i = '0;
    logic          beep_wr_i = 1'b0;
    logic [2:0]    beep_ctrl_i = '0;
    logic [PW-1:0] pin_pull_low_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    beep_port #(.PORT_W(PW), .HALF_A(HA), .HALF_B(HB)) i_beep_port (
        .clk            (clk),
        .rst_n          (rst_n),
        .backup_i       (backup_i),
        .port_wr_i      (port_wr_i),
        .port_data_i    (port_data_i),
        .beep_wr_i      (beep_wr_i),
        .beep_ctrl_i    (beep_ctrl_i),
        .pin_pull_low_o (pin_pull_low_o)
    );

    // entry: [8] write, [7:6] data, [5] beep, [4:2] ctrl, [1:0] expected pull-low
    localparam int NV = 6;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 2'b00, 1'b0, 3'b000, 2'b11},
        {1'b1, 2'b10, 1'b0, 3'b000, 2'b01},
        {1'b1, 2'b01, 1'b0, 3'b000, 2'b10},
        {1'b1, 2'b11, 1'b0, 3'b000, 2'b00},
        {1'b0, 2'b00, 1'b1, 3'b000, 2'b00},
        {1'b1, 2'b00, 1'b0, 3'b000, 2'b11}
    };

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        port_wr_i = 1'b0;
        beep_wr_i = 1'b0;
        backup_i  = 1'b0;
    endtask

    // apply strobes at a falling edge, clock them in, check at the next falling edge
    task automatic cmd(input logic wr, input logic [PW-1:0] d, input logic bp,
                       input logic [2:0] c, input logic bk);
        @(negedge clk);
        port_wr_i = wr; port_data_i = d;
        beep_wr_i = bp; beep_ctrl_i = c;
        backup_i  = bk;
        @(negedge clk);
        idle();
    endtask

    // after a tone command: sample 4*h cycles; optional write at sample wr_at
    task automatic tone_run(input string req, input int h, input int wr_at,
                            input logic [PW-1:0] wdata, input logic b1_before);
        logic b1_exp;
        @(negedge clk);
        port_wr_i = 1'b0; beep_wr_i = 1'b0; backup_i = 1'b0;
        port_wr_i = 1'b1; port_data_i = '1; beep_wr_i = 1'b1;
        port_wr_i = 1'b0;
        b1_exp = b1_before;
        @(negedge clk);
        beep_wr_i = 1'b0;
        for (int n = 0; n < 4 * h; n++) begin
            if (n > wr_at && wr_at >= 0) b1_exp = ~wdata[1];
            check(req, pin_pull_low_o[0], ((n / h) % 2) == 1);
            check("R7", pin_pull_low_o[1], b1_exp);
            if (n == wr_at) begin
                port_wr_i = 1'b1; port_data_i = wdata;
            end else begin
                port_wr_i = 1'b0;
            end
            @(negedge clk);
        end
        port_wr_i = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pin_pull_low_o, 2'b00);

        // R2 / R8: latch-mode vector table
        for (int v = 0; v < NV; v++) begin
            cmd(VEC[v][8], VEC[v][7:6], VEC[v][5], VEC[v][4:2], 1'b0);
            check("R2", pin_pull_low_o, VEC[v][1:0]);
        end

        // latch now 00 -> both pulled low; bit1 pull-low = 1 during tones
        // R3: code 00
        beep_ctrl_i = 3'b100;
        tone_run("R3", HA, -1, '0, 1'b1);
        // R4: code 01
        beep_ctrl_i = 3'b101;
        tone_run("R4", HB, -1, '0, 1'b1);
        // R5: codes 10 and 11
        beep_ctrl_i = 3'b110;
        tone_run("R5", HA, -1, '0, 1'b1);
        beep_ctrl_i = 3'b111;
        tone_run("R5", HA, -1, '0, 1'b1);
        // R6 / R7: write mid-tone, bit0 pattern undisturbed, bit1 follows
        beep_ctrl_i = 3'b100;
        tone_run("R6", HA, 2, 2'b10, 1'b1);

        // R8: back to latch mode shows latch 10 -> pull-low 01
        cmd(1'b0, '0, 1'b1, 3'b000, 1'b0);
        check("R8", pin_pull_low_o, 2'b01);

        // R9: backup releases and stays released
        cmd(1'b1, 2'b00, 1'b0, 3'b000, 1'b0);
        check("R2", pin_pull_low_o, 2'b11);
        cmd(1'b0, '0, 1'b0, 3'b000, 1'b1);
        check("R9", pin_pull_low_o, 2'b00);
        repeat (3) @(negedge clk);
        check("R9", pin_pull_low_o, 2'b00);
        // write while backup held: still released
        cmd(1'b1, 2'b01, 1'b0, 3'b000, 1'b1);
        check("R9", pin_pull_low_o, 2'b00);
        // R10: beep command wakes, shows latch 01 -> pull-low 10
        cmd(1'b0, '0, 1'b1, 3'b000, 1'b0);
        check("R10", pin_pull_low_o, 2'b10);
        // R10: backup then port write wakes with new value
        cmd(1'b0, '0, 1'b0, 3'b000, 1'b1);
        check("R9", pin_pull_low_o, 2'b00);
        cmd(1'b1, 2'b10, 1'b0, 3'b000, 1'b0);
        check("R10", pin_pull_low_o, 2'b01);

        // R1: reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pin_pull_low_o, 2'b00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule